// File: doc/BRIEF.md
# Interrupt-Capable General-Purpose Pin Bank

A memory-mapped bank of up to 32 general-purpose pins on a plain 32-bit register bus. Each pin works as an ordinary input, an ordinary output, or an interrupt source. Interrupt sources can each be set to level or edge sensing. Each one has its own active polarity, and edge sensing can also be set to fire on both transitions. Edge events are latched into a status register until software clears them. Level-sensed status follows the pin with no latch. An enable mask gates the status bits onto one combined interrupt line. That mask has a direct-write port and a separate write-one-to-enable port.

Pin inputs pass through a two-flop synchroniser, and a third flop keeps the previous sample for edge finding. Register reads are combinational on the address. Writes take effect at the clock edge where `bus_sel` and `bus_wr` are both high. A parameter picks how the input-data register reports pins that are driven as outputs. In the tracking variant it always shows the synchronised pin. In the legacy variant those bits read as zero, and software reads the output-data register for them instead.

The block has no sequencing state machine. Every register updates in one cycle. Each pin's interrupt path has two named conditions: **idle** (latch clear) and **pending** (latch set). The pin goes from idle to pending on a qualifying edge. It goes from pending to idle on a clear write with no coincident edge, or when the pin leaves edge-interrupt mode.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset every register reads zero, `pin_oe` is all zero (every pin an input) and `irq` is low.
- R2: `pin_oe[i]` is 1 exactly when bit i of the mode register (offset 0x00, 1 = interrupt input) is 0 and bit i of the direction register (offset 0x04, 1 = output) is 1.
- R3: `pin_out` always equals the output-data register (offset 0x08). Written registers read back the written value.
- R4: With `IN_TRACKS_ALL`=1, the input-data register (offset 0x0C) shows the pin state. It is readable after the second rising clock edge following a pin change.
- R5: With `IN_TRACKS_ALL`=0, input-data bits of pins whose `pin_oe` is 1 read 0. All other bits show the synchronised pin state.
- R6: A pin in interrupt mode with its sense bit (offset 0x24) set to 1 is edge sensed. Its status bit (offset 0x10) latches on a rising edge when its polarity bit (offset 0x20) is 0, or on a falling edge when it is 1. The bit stays set after the pin returns.
- R7: An edge-sensed pin with its both-edge bit (offset 0x4C) set to 1 latches status on either transition, whatever the polarity bit holds.
- R8: A pin in interrupt mode with sense bit 0 is level sensed. Its status is 1 while the synchronised pin equals the active level (high for polarity 0, low for polarity 1). There is no latch, and clear writes have no effect on it.
- R9: Writing to offset 0x14 clears the status bits written as 1 and leaves the rest. If an edge event and a clear hit the same bit in the same cycle, the bit stays set.
- R10: A write to offset 0x18 stores the mask as written. A write to offset 0x1C sets the mask bits written as 1 and leaves the others unchanged.
- R11: `irq` is high exactly when some pin has both its status bit and its mask bit set.
- R12: A pin with mode bit 0 never shows a status bit, whatever its sense, polarity and both-edge settings and its pin activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, zero when not reading |
| pin_in | input | NPINS | Raw pin levels (asynchronous) |
| pin_out | output | NPINS | Output-data levels |
| pin_oe | output | NPINS | Output enable per pin |
| irq | output | 1 | Combined interrupt request |

## Verification
Errors in the configuration registers show up at once on `pin_oe` and `pin_out`, so those are compared against a reference on every clock. A wrong edge latch stays hidden until the matching mask bit is set. It then shows on `irq` in the same cycle and on a status read. A wrong synchroniser depth shifts status and input data by whole cycles, so those are read at the exact edge the requirements name. A missed same-cycle edge-versus-clear collision would only surface as a lost interrupt, so the bench forces that collision on purpose.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
    localparam int REG_AW = 8;
    localparam int BUS_W  = 32;

    typedef enum logic [REG_AW-1:0] {
        OFF_MODE   = 8'h00,
        OFF_DIR    = 8'h04,
        OFF_DOUT   = 8'h08,
        OFF_DIN    = 8'h0C,
        OFF_STAT   = 8'h10,
        OFF_CLR    = 8'h14,
        OFF_MASK   = 8'h18,
        OFF_UNMASK = 8'h1C,
        OFF_POL    = 8'h20,
        OFF_SENSE  = 8'h24,
        OFF_BOTH   = 8'h4C
    } reg_off_e;
endpackage

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
    import gpio_bank_pkg::*;
#(
    parameter int N = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel,
    input  logic              wr,
    input  logic [REG_AW-1:0] addr,
    input  logic [BUS_W-1:0]  wdata,
    input  logic [N-1:0]      din_view,
    input  logic [N-1:0]      stat,
    output logic [N-1:0]      mode_q,
    output logic [N-1:0]      dir_q,
    output logic [N-1:0]      dout_q,
    output logic [N-1:0]      mask_q,
    output logic [N-1:0]      pol_q,
    output logic [N-1:0]      sense_q,
    output logic [N-1:0]      both_q,
    output logic [N-1:0]      clr_hit,
    output logic [BUS_W-1:0]  rdata
);
    logic         wr_en;
    logic         rd_en;
    logic [N-1:0] wval;
    logic [N-1:0] rsel;

    assign wr_en = sel & wr;
    assign rd_en = sel & ~wr;
    assign wval  = wdata[N-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= '0;
            dir_q   <= '0;
            dout_q  <= '0;
            mask_q  <= '0;
            pol_q   <= '0;
            sense_q <= '0;
            both_q  <= '0;
        end else if (wr_en) begin
            case (addr)
                OFF_MODE:   mode_q  <= wval;
                OFF_DIR:    dir_q   <= wval;
                OFF_DOUT:   dout_q  <= wval;
                OFF_MASK:   mask_q  <= wval;
                OFF_UNMASK: mask_q  <= mask_q | wval;
                OFF_POL:    pol_q   <= wval;
                OFF_SENSE:  sense_q <= wval;
                OFF_BOTH:   both_q  <= wval;
                default:    ;
            endcase
        end
    end

    assign clr_hit = (wr_en && addr == OFF_CLR) ? wval : '0;

    always_comb begin
        rsel = '0;
        if (rd_en) begin
            case (addr)
                OFF_MODE:  rsel = mode_q;
                OFF_DIR:   rsel = dir_q;
                OFF_DOUT:  rsel = dout_q;
                OFF_DIN:   rsel = din_view;
                OFF_STAT:  rsel = stat;
                OFF_MASK:  rsel = mask_q;
                OFF_POL:   rsel = pol_q;
                OFF_SENSE: rsel = sense_q;
                OFF_BOTH:  rsel = both_q;
                default:   rsel = '0;
            endcase
        end
        rdata        = '0;
        rdata[N-1:0] = rsel;
    end
endmodule

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] pin_raw,
    output logic [N-1:0] cur,
    output logic [N-1:0] prev
);
    logic [N-1:0] meta_q;
    logic [N-1:0] cur_q;
    logic [N-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            cur_q  <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= pin_raw;
            cur_q  <= meta_q;
            prev_q <= cur_q;
        end
    end

    assign cur  = cur_q;
    assign prev = prev_q;
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] cur,
    input  logic [N-1:0] prev,
    input  logic [N-1:0] mode,
    input  logic [N-1:0] pol,
    input  logic [N-1:0] sense,
    input  logic [N-1:0] both,
    input  logic [N-1:0] clr,
    output logic [N-1:0] evt,
    output logic [N-1:0] latch,
    output logic [N-1:0] stat
);
    for (genvar i = 0; i < N; i++) begin : g_pin
        logic rise;
        logic fall;
        logic armed;
        logic pend_q;

        assign rise  = cur[i] & ~prev[i];
        assign fall  = ~cur[i] & prev[i];
        assign armed = mode[i] & sense[i];

        always_comb begin
            if (!armed)
                evt[i] = 1'b0;
            else if (both[i])
                evt[i] = rise | fall;
            else
                evt[i] = pol[i] ? fall : rise;
        end

        // idle -> pending on an event; pending -> idle on clear or disarm
        always_ff @(posedge clk) begin
            if (rst)
                pend_q <= 1'b0;
            else if (!armed)
                pend_q <= 1'b0;
            else if (evt[i])
                pend_q <= 1'b1;
            else if (clr[i])
                pend_q <= 1'b0;
        end

        assign latch[i] = pend_q;

        always_comb begin
            if (!mode[i])
                stat[i] = 1'b0;
            else if (sense[i])
                stat[i] = pend_q;
            else
                stat[i] = cur[i] ^ pol[i];
        end
    end
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
    import gpio_bank_pkg::*;
#(
    parameter int NPINS         = 32,
    parameter bit IN_TRACKS_ALL = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe,
    output logic              irq
);
    logic [NPINS-1:0] mode_q, dir_q, dout_q, mask_q, pol_q, sense_q, both_q;
    logic [NPINS-1:0] clr_hit;
    logic [NPINS-1:0] cur_w, prev_w;
    logic [NPINS-1:0] evt_w, latch_w, stat_w;
    logic [NPINS-1:0] din_view;

    gpio_pin_sync #(.N(NPINS)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .pin_raw (pin_in),
        .cur     (cur_w),
        .prev    (prev_w)
    );

    gpio_irq_detect #(.N(NPINS)) u_det (
        .clk   (clk),
        .rst   (rst),
        .cur   (cur_w),
        .prev  (prev_w),
        .mode  (mode_q),
        .pol   (pol_q),
        .sense (sense_q),
        .both  (both_q),
        .clr   (clr_hit),
        .evt   (evt_w),
        .latch (latch_w),
        .stat  (stat_w)
    );

    gpio_bank_regs #(.N(NPINS)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .sel      (bus_sel),
        .wr       (bus_wr),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .din_view (din_view),
        .stat     (stat_w),
        .mode_q   (mode_q),
        .dir_q    (dir_q),
        .dout_q   (dout_q),
        .mask_q   (mask_q),
        .pol_q    (pol_q),
        .sense_q  (sense_q),
        .both_q   (both_q),
        .clr_hit  (clr_hit),
        .rdata    (bus_rdata)
    );

    assign pin_oe  = ~mode_q & dir_q;
    assign pin_out = dout_q;
    assign irq     = |(stat_w & mask_q);

    if (IN_TRACKS_ALL) begin : g_din_track
        assign din_view = cur_w;
    end else begin : g_din_legacy
        assign din_view = cur_w & ~pin_oe;
    end
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk
    import gpio_bank_pkg::*;
#(
    parameter int N = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              sel,
    input logic              wr,
    input logic [REG_AW-1:0] addr,
    input logic [BUS_W-1:0]  wdata,
    input logic              irq,
    input logic [N-1:0]      mode,
    input logic [N-1:0]      mask,
    input logic [N-1:0]      stat,
    input logic [N-1:0]      evt,
    input logic [N-1:0]      latch
);
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        $fell(rst) |-> (!irq && mask == '0 && stat == '0));

    a_r10_mask_store: assert property (@(posedge clk) disable iff (rst)
        (sel && wr && addr == OFF_MASK) |=> (mask == $past(wdata[N-1:0])));

    a_r10_unmask_sets: assert property (@(posedge clk) disable iff (rst)
        (sel && wr && addr == OFF_UNMASK) |=>
            ((mask & $past(wdata[N-1:0])) == $past(wdata[N-1:0])));

    a_r9_clear_takes: assert property (@(posedge clk) disable iff (rst)
        (sel && wr && addr == OFF_CLR && (evt & wdata[N-1:0]) == '0) |=>
            ((latch & $past(wdata[N-1:0])) == '0));

    a_r9_event_wins: assert property (@(posedge clk) disable iff (rst)
        (|evt) |=> ((latch & $past(evt)) == $past(evt)));

    a_r12_io_no_status: assert property (@(posedge clk) disable iff (rst)
        ((stat & ~mode) == '0));
endmodule

bind gpio_irq_bank gpio_bank_chk #(.N(NPINS)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .sel   (bus_sel),
    .wr    (bus_wr),
    .addr  (bus_addr),
    .wdata (bus_wdata),
    .irq   (irq),
    .mode  (mode_q),
    .mask  (mask_q),
    .stat  (stat_w),
    .evt   (evt_w),
    .latch (latch_w)
);

// File: tb/sim_gpio_irq_bank.sv
module sim_gpio_irq_bank;
    localparam int N = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          sel = 1'b0;
    logic          wr  = 1'b0;
    logic [7:0]    addr = '0;
    logic [31:0]   wdata = '0;
    logic [N-1:0]  ext = '0;
    logic [31:0]   rd0, rd1;
    logic [N-1:0]  out0, oe0, out1, oe1;
    logic          irq0, irq1;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    gpio_irq_bank #(.NPINS(N), .IN_TRACKS_ALL(1'b1)) u0 (
        .clk(clk), .rst(rst), .bus_sel(sel), .bus_wr(wr), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rd0), .pin_in(ext), .pin_out(out0),
        .pin_oe(oe0), .irq(irq0));

    gpio_irq_bank #(.NPINS(N), .IN_TRACKS_ALL(1'b0)) u1 (
        .clk(clk), .rst(rst), .bus_sel(sel), .bus_wr(wr), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rd1), .pin_in(ext), .pin_out(out1),
        .pin_oe(oe1), .irq(irq1));

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    bit [31:0] m_mode, m_dir, m_dout, m_mask, m_pol, m_sense, m_both, m_pend;
    bit [31:0] h1, h2, h3;   // pin history: newest sampled, synchronised, previous

    function automatic bit [31:0] m_status();
        bit [31:0] s = '0;
        for (int i = 0; i < N; i++) begin
            if (m_mode[i]) s[i] = m_sense[i] ? m_pend[i] : (h2[i] != m_pol[i]);
        end
        return s;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_mode = 0; m_dir = 0; m_dout = 0; m_mask = 0; m_pol = 0;
            m_sense = 0; m_both = 0; m_pend = 0; h1 = 0; h2 = 0; h3 = 0;
        end else begin
            for (int i = 0; i < N; i++) begin
                bit hit;
                bit went_up, went_down;
                went_up   = h2[i] && !h3[i];
                went_down = !h2[i] && h3[i];
                if (m_both[i]) hit = went_up || went_down;
                else if (m_pol[i]) hit = went_down;
                else hit = went_up;
                if (!(m_mode[i] && m_sense[i])) m_pend[i] = 0;
                else if (hit) m_pend[i] = 1;
                else if (sel && wr && addr == 8'h14 && wdata[i]) m_pend[i] = 0;
            end
            if (sel && wr) begin
                case (addr)
                    8'h00: m_mode  = wdata;
                    8'h04: m_dir   = wdata;
                    8'h08: m_dout  = wdata;
                    8'h18: m_mask  = wdata;
                    8'h1C: m_mask  = m_mask | wdata;
                    8'h20: m_pol   = wdata;
                    8'h24: m_sense = wdata;
                    8'h4C: m_both  = wdata;
                    default: ;
                endcase
            end
            h3 = h2; h2 = h1; h1 = ext;
        end
        #2;
        check("R11 irq vs model (u0)", {31'd0, irq0}, {31'd0, |(m_status() & m_mask)});
        check("R11 irq vs model (u1)", {31'd0, irq1}, {31'd0, |(m_status() & m_mask)});
        check("R2 pin_oe vs model", oe0, ~m_mode & m_dir);
        check("R3 pin_out vs model", out0, m_dout);
    end

    // ---------------- bus helpers ----------------
    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0; wdata = '0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d0, output logic [31:0] d1);
        @(negedge clk);
        sel = 1'b1; wr = 1'b0; addr = a;
        #1;
        d0 = rd0; d1 = rd1;
        sel = 1'b0;
    endtask

    task automatic expect_reg(input string tag, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] v0, v1;
        bus_read(a, v0, v1);
        check(tag, v0, exp);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; ext = '0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic set_pins(input logic [31:0] v);
        @(negedge clk);
        ext = v;
    endtask

    initial begin
        logic [31:0] a0, a1;
        do_reset();

        // R1 reset state
        expect_reg("R1 mode after reset", 8'h00, 32'h0);
        expect_reg("R1 dir after reset", 8'h04, 32'h0);
        expect_reg("R1 dout after reset", 8'h08, 32'h0);
        expect_reg("R1 mask after reset", 8'h18, 32'h0);
        expect_reg("R1 status after reset", 8'h10, 32'h0);
        check("R1 oe after reset", oe0, 32'h0);
        check("R1 irq after reset", {31'd0, irq0}, 32'h0);

        // R2 / R3 direction and output data
        bus_write(8'h08, 32'hA5A5_0F0F);
        bus_write(8'h04, 32'h0000_FFFF);
        #1;
        check("R2 oe from direction", oe0, 32'h0000_FFFF);
        check("R3 pin_out", out0, 32'hA5A5_0F0F);
        expect_reg("R3 dout readback", 8'h08, 32'hA5A5_0F0F);
        expect_reg("R3 dir readback", 8'h04, 32'h0000_FFFF);
        bus_write(8'h00, 32'h0000_000F);
        #1;
        check("R2 interrupt mode drops oe", oe0, 32'h0000_FFF0);

        // R4 / R5 input data views
        set_pins(32'h1234_5678);
        repeat (2) @(posedge clk);
        bus_read(8'h0C, a0, a1);
        check("R4 input data tracks pins", a0, 32'h1234_5678);
        check("R5 legacy hides output pins", a1, 32'h1234_0008);

        // R6 rising and falling edge latch
        do_reset();
        bus_write(8'h00, 32'h1);
        bus_write(8'h24, 32'h1);
        bus_write(8'h1C, 32'h1);
        set_pins(32'h1);
        repeat (3) @(posedge clk);
        expect_reg("R6 rising edge latches", 8'h10, 32'h1);
        check("R11 irq on masked-in status", {31'd0, irq0}, 32'h1);
        set_pins(32'h0);
        repeat (3) @(posedge clk);
        expect_reg("R6 status sticks after return", 8'h10, 32'h1);
        bus_write(8'h14, 32'h1);
        expect_reg("R9 clear drops status", 8'h10, 32'h0);
        bus_write(8'h20, 32'h1);
        set_pins(32'h1);
        repeat (3) @(posedge clk);
        expect_reg("R6 falling polarity ignores rise", 8'h10, 32'h0);
        set_pins(32'h0);
        repeat (3) @(posedge clk);
        expect_reg("R6 falling edge latches", 8'h10, 32'h1);
        bus_write(8'h14, 32'h1);

        // R7 both edges
        bus_write(8'h4C, 32'h1);
        set_pins(32'h1);
        repeat (3) @(posedge clk);
        expect_reg("R7 both-edge rise", 8'h10, 32'h1);
        bus_write(8'h14, 32'h1);
        expect_reg("R7 cleared", 8'h10, 32'h0);
        set_pins(32'h0);
        repeat (3) @(posedge clk);
        expect_reg("R7 both-edge fall", 8'h10, 32'h1);

        // R8 level sensing
        do_reset();
        bus_write(8'h00, 32'h2);
        bus_write(8'h1C, 32'h2);
        expect_reg("R8 low level inactive", 8'h10, 32'h0);
        set_pins(32'h2);
        repeat (2) @(posedge clk);
        expect_reg("R8 high level active", 8'h10, 32'h2);
        bus_write(8'h14, 32'h2);
        expect_reg("R8 clear has no effect on level", 8'h10, 32'h2);
        set_pins(32'h0);
        repeat (2) @(posedge clk);
        expect_reg("R8 no latch after level drops", 8'h10, 32'h0);
        check("R8 irq drops with level", {31'd0, irq0}, 32'h0);
        bus_write(8'h20, 32'h2);
        expect_reg("R8 active-low level", 8'h10, 32'h2);

        // R9 collision and partial clear
        do_reset();
        bus_write(8'h00, 32'h5);
        bus_write(8'h24, 32'h5);
        set_pins(32'h1);
        repeat (2) @(posedge clk);
        bus_write(8'h14, 32'h1);      // lands on the edge cycle
        expect_reg("R9 edge beats same-cycle clear", 8'h10, 32'h1);
        set_pins(32'h5);
        repeat (3) @(posedge clk);
        expect_reg("R9 two pins latched", 8'h10, 32'h5);
        bus_write(8'h14, 32'h1);
        expect_reg("R9 zero bits untouched", 8'h10, 32'h4);

        // R10 / R11 mask ports
        bus_write(8'h18, 32'hF0);
        expect_reg("R10 direct mask write", 8'h18, 32'hF0);
        check("R11 masked status gives no irq", {31'd0, irq0}, 32'h0);
        bus_write(8'h1C, 32'h03);
        expect_reg("R10 unmask sets bits", 8'h18, 32'hF3);
        check("R11 unrelated mask bits no irq", {31'd0, irq0}, 32'h0);
        bus_write(8'h18, 32'h01);
        expect_reg("R10 direct write clears bits", 8'h18, 32'h01);
        bus_write(8'h1C, 32'h04);
        #1;
        check("R11 irq after unmask", {31'd0, irq0}, 32'h1);

        // R12 general-I/O pins never flag
        do_reset();
        bus_write(8'h24, 32'h1);
        bus_write(8'h4C, 32'h1);
        bus_write(8'h1C, 32'h1);
        set_pins(32'h1);
        repeat (3) @(posedge clk);
        set_pins(32'h0);
        repeat (3) @(posedge clk);
        expect_reg("R12 io pin has no status", 8'h10, 32'h0);
        check("R12 io pin no irq", {31'd0, irq0}, 32'h0);

        repeat (2) @(posedge clk);
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        #2_000_000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule